// File: doc/BRIEF.md
# Reciprocal-Scaled Constant Divider

This block divides a stream of unsigned dividends by a divisor that changes only now and then. It does not run a full division for every sample. When a divisor Y is loaded, a sequential restoring divider works out the scaled reciprocal K = floor(2^S / Y). The divider produces one quotient bit per cycle by subtracting and then shifting. After that, each accepted dividend X gives the quotient floor(X·K / 2^S) through a single registered multiply and right shift. With the default S = 10 the scale is 1024.

The result is an approximation. Because K is truncated, the quotient can sit one below the exact floor(X/Y), and the error grows as X grows. While the reciprocal is being computed the block lowers its ready signal, so no dividend is taken with a half-built K. A zero divisor raises an error flag, and every quotient then reads as all ones until a nonzero divisor is loaded.

Top module: `recip_div_const`

## Requirements
- R1: After reset, busy, out_valid and div_err are 0 and in_ready is 1.
- R2: A divisor load is taken on a clock edge where ld_valid is 1 and busy is 0. busy is then 1 for exactly S+1 = 11 cycles. in_ready equals (not busy) and (not ld_valid).
- R3: After a load of a nonzero Y, each quotient equals floor(X·floor(1024/Y)/1024), using unsigned 16-bit X and Y. Examples: X=300 with Y=14 gives 21, and Y=1 gives X unchanged.
- R4: A dividend is accepted on an edge where in_valid and in_ready are both 1. Its quotient appears on out_data with out_valid=1 in the next cycle. Back-to-back dividends give back-to-back quotients in the same order.
- R5: A dividend presented while in_ready is 0 is dropped and produces no out_valid pulse.
- R6: ld_valid while busy is 1 is ignored, and the reciprocal of the divisor already being processed is kept.
- R7: Loading Y=0 sets div_err to 1 after the load edge, and every quotient is then 0xFFFF. A later nonzero load clears div_err.
- R8: For a nonzero Y, the quotient never exceeds X. For X ≤ 1023 it is floor(X/Y) or one less.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_valid | input | 1 | Request to load a new divisor |
| ld_divisor | input | 16 | Divisor value to load |
| busy | output | 1 | Reciprocal computation in progress |
| in_valid | input | 1 | Dividend present |
| in_data | input | 16 | Unsigned dividend |
| in_ready | output | 1 | Dividend can be taken this cycle |
| out_valid | output | 1 | Quotient present |
| out_data | output | 16 | Quotient |
| div_err | output | 1 | Loaded divisor is zero |

## Verification
The bench targets the following corner cases and the failure each one would expose:

- Y=1, where K reaches its largest value 2^S. A design with a reciprocal register one bit too narrow would wrap K to zero and return 0 instead of X.
- Y=65535, where K is zero, and a large Y such as 1000, where K is one. A faulty divider that left a stale remainder would return nonzero or wrong quotients.
- An exact count of busy cycles, plus dividends and divisor loads offered during busy. An off-by-one iteration count would show up as a doubled or halved K. A missing ready gate would let a quotient escape that was computed from a half-built K.
- A zero divisor, and the return from it. A design missing this would give finite garbage instead of all ones, or keep the error after a good load.

// File: rtl/recip_div_pkg.sv
package recip_div_pkg;
  typedef enum logic [0:0] {
    ENG_IDLE = 1'b0,
    ENG_RUN  = 1'b1
  } eng_state_t;
endpackage

// File: rtl/recip_engine.sv
module recip_engine #(
  parameter int YW = 16,
  parameter int S  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [YW-1:0]     divisor,
  output logic              busy_o,
  output logic              last_step_o,
  output logic              zero_o,
  output logic [S:0]        k_o
);
  import recip_div_pkg::*;

  localparam int KW = S + 1;
  localparam int CW = $clog2(KW + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(KW);
  localparam logic [KW-1:0] K_MAX    = KW'(1) << S;

  // One restoring step: bring in one numerator bit, subtract if it fits.
  // Result: {quotient bit, new remainder}.
  function automatic logic [YW:0] div_step(input logic [YW-1:0] r,
                                           input logic          nbit,
                                           input logic [YW-1:0] y);
    logic [YW:0] trial;
    trial = {r, nbit};
    if (trial >= {1'b0, y}) begin
      div_step = {1'b1, YW'(trial - {1'b0, y})};
    end else begin
      div_step = {1'b0, trial[YW-1:0]};
    end
  endfunction

  eng_state_t       st;
  logic [CW-1:0]    cnt;
  logic [YW-1:0]    rem;
  logic [YW-1:0]    yreg;
  logic [KW-1:0]    quo;
  logic             zero_q;
  logic             num_bit;
  logic [YW:0]      step_res;

  // The numerator 2^S has a single one, in its top bit (first iteration).
  assign num_bit  = (cnt == CNT_FULL);
  assign step_res = div_step(rem, num_bit, yreg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ENG_IDLE;
      cnt    <= '0;
      rem    <= '0;
      yreg   <= '0;
      quo    <= '0;
      zero_q <= 1'b0;
    end else begin
      case (st)
        ENG_IDLE: begin
          if (start) begin
            yreg   <= divisor;
            zero_q <= (divisor == '0);
            rem    <= '0;
            quo    <= '0;
            cnt    <= CNT_FULL;
            st     <= ENG_RUN;
          end
        end
        default: begin
          rem <= step_res[YW-1:0];
          quo <= {quo[KW-2:0], step_res[YW]};
          cnt <= cnt - 1'b1;
          if (cnt == CW'(1)) st <= ENG_IDLE;
        end
      endcase
    end
  end

  assign busy_o      = (st == ENG_RUN);
  assign last_step_o = busy_o && (cnt == CW'(1));
  assign zero_o      = zero_q;
  assign k_o         = quo;

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_o) |=> busy_o);
  assert_run_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    last_step_o |=> !busy_o);
  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (cnt != '0 && cnt <= CNT_FULL));
  assert_k_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !zero_q) |-> (k_o <= K_MAX));
  assert_ignore_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !last_step_o) |=> $stable(yreg));
endmodule

// File: rtl/scale_mult.sv
module scale_mult #(
  parameter int XW = 16,
  parameter int KW = 11,
  parameter int S  = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           accept,
  input  logic [XW-1:0]  x,
  input  logic [KW-1:0]  k,
  input  logic           force_ones,
  output logic           vld_o,
  output logic [XW-1:0]  q_o
);
  localparam int PW = XW + KW;

  // Multiply by the scaled reciprocal, then drop the S scale bits.
  function automatic logic [XW-1:0] mul_shift(input logic [XW-1:0] xv,
                                              input logic [KW-1:0] kv);
    logic [PW-1:0] prod;
    prod = PW'(xv) * PW'(kv);
    mul_shift = XW'(prod >> S);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      q_o   <= '0;
    end else begin
      vld_o <= accept;
      if (accept) q_o <= force_ones ? '1 : mul_shift(x, k);
    end
  end

  assert_one_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> vld_o);
  assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !vld_o);
  assert_err_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && force_ones) |=> (q_o == '1));
  assert_quot_le_x_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !force_ones && k <= (KW'(1) << S)) |=> (q_o <= $past(x)));
endmodule

// File: rtl/recip_div_const.sv
module recip_div_const #(
  parameter int XW = 16,
  parameter int YW = 16,
  parameter int S  = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld_valid,
  input  logic [YW-1:0]  ld_divisor,
  output logic           busy,
  input  logic           in_valid,
  input  logic [XW-1:0]  in_data,
  output logic           in_ready,
  output logic           out_valid,
  output logic [XW-1:0]  out_data,
  output logic           div_err
);
  localparam int KW = S + 1;

  logic          eng_start;
  logic          eng_busy;
  logic          eng_last;
  logic          eng_zero;
  logic [KW-1:0] eng_k;
  logic          x_accept;

  assign eng_start = ld_valid && !eng_busy;
  assign in_ready  = !eng_busy && !ld_valid;
  assign x_accept  = in_valid && in_ready;

  recip_engine #(.YW(YW), .S(S)) u_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (eng_start),
    .divisor     (ld_divisor),
    .busy_o      (eng_busy),
    .last_step_o (eng_last),
    .zero_o      (eng_zero),
    .k_o         (eng_k)
  );

  scale_mult #(.XW(XW), .KW(KW), .S(S)) u_mult (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (x_accept),
    .x          (in_data),
    .k          (eng_k),
    .force_ones (eng_zero),
    .vld_o      (out_valid),
    .q_o        (out_data)
  );

  assign busy    = eng_busy;
  assign div_err = eng_zero;

  assert_no_out_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |=> !out_valid);
  assert_ready_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    x_accept |-> (!eng_busy && !eng_start));
  assert_err_on_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start && ld_divisor == '0) |=> div_err);
  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_last |=> in_ready || ld_valid);
endmodule

// File: tb/test_recip_div_const.sv
module test_recip_div_const;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic [15:0] ld_divisor = '0;
  logic        busy;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        in_ready;
  logic        out_valid;
  logic [15:0] out_data;
  logic        div_err;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  recip_div_const i_recip_div_const (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_divisor(ld_divisor),
    .busy(busy), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .div_err(div_err)
  );

  // Independent model: integer reciprocal of 1024, product, divide by 1024.
  function automatic longint model_q(input longint x, input longint y);
    longint recip;
    if (y == 0) return 65535;
    recip = 1024 / y;
    return (x * recip) / 1024;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 div_err", div_err, 0);
    chk("R1 in_ready", in_ready, 1);
  endtask

  task automatic t_load(input logic [15:0] y);
    int n;
    @(negedge clk);
    ld_valid = 1'b1; ld_divisor = y;
    #1 chk("R2 in_ready low with ld_valid", in_ready, 0);
    @(negedge clk);
    ld_valid = 1'b0;
    n = 0;
    while (busy && n < 50) begin
      n++;
      if (in_ready) chk("R2 in_ready during busy", in_ready, 0);
      @(negedge clk);
    end
    chk("R2 busy cycles", n, 11);
    chk("R7 div_err after load", div_err, (y == 0) ? 1 : 0);
  endtask

  task automatic t_div(input logic [15:0] x, input logic [15:0] y);
    longint q;
    @(negedge clk);
    in_valid = 1'b1; in_data = x;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R4 out_valid", out_valid, 1);
    chk("R3 quotient", out_data, model_q(x, y));
    if (y != 0) begin
      q = out_data;
      chk("R8 quotient not above X", (q <= x) ? 1 : 0, 1);
      if (x <= 1023)
        chk("R8 within one of exact", ((q == x / y) || (q + 1 == x / y)) ? 1 : 0, 1);
    end
    @(negedge clk);
    chk("R4 single pulse", out_valid, 0);
  endtask

  task automatic t_stream(input logic [15:0] y);
    logic [15:0] xs [4];
    xs[0] = 16'd1000; xs[1] = 16'd17; xs[2] = 16'd65535; xs[3] = 16'd512;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk("R4 stream valid", out_valid, 1);
        chk("R4 stream order", out_data, model_q(xs[i-1], y));
      end
      in_valid = 1'b1; in_data = xs[i];
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk("R4 stream valid", out_valid, 1);
    chk("R4 stream order", out_data, model_q(xs[3], y));
  endtask

  task automatic t_busy_drop();
    @(negedge clk);
    ld_valid = 1'b1; ld_divisor = 16'd5;
    @(negedge clk);
    ld_valid = 1'b0;
    in_valid = 1'b1; in_data = 16'd500;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (out_valid) chk("R5 no output while busy", out_valid, 0);
    end
    in_valid = 1'b0;
    @(negedge clk);
    chk("R5 dropped dividend gave no output", out_valid, 0);
    chk("R5 engine idle", busy, 0);
    t_div(16'd500, 16'd5);
  endtask

  task automatic t_load_while_busy();
    @(negedge clk);
    ld_valid = 1'b1; ld_divisor = 16'd14;
    @(negedge clk);
    ld_divisor = 16'd3;
    @(negedge clk);
    ld_valid = 1'b0;
    while (busy) @(negedge clk);
    t_div(16'd300, 16'd14);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load(16'd14);   t_div(16'd300, 16'd14);
    t_div(16'd1023, 16'd14);
    t_load(16'd1);    t_div(16'd65535, 16'd1); t_div(16'd777, 16'd1);
    t_load(16'd3);    t_div(16'd1000, 16'd3);  t_stream(16'd3);
    t_load(16'd7);    t_div(16'd1023, 16'd7);  t_div(16'd0, 16'd7);
    t_load(16'd1000); t_div(16'd65535, 16'd1000);
    t_load(16'd65535); t_div(16'd65535, 16'd65535);
    t_load(16'd1023); t_div(16'd1023, 16'd1023);
    t_busy_drop();
    t_load_while_busy();
    t_load(16'd0);    t_div(16'd300, 16'd0); t_div(16'd0, 16'd0);
    t_load(16'd9);    chk("R7 error cleared", div_err, 0);
    t_div(16'd54, 16'd9);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=finish", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end
endmodule